// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a synchronous up counter built from 4-bit slices. Each slice steps on the rising clock edge. Each slice can be preset from a parallel data word through an active-low load strobe, and it can be zeroed through an active-low clear. Counting needs two active-high enables. The first, `cnt_en`, only allows counting. The second, `carry_en`, allows counting and also gates the slice's carry-out. Slices are chained by feeding each slice's carry-out into the `carry_en` of the slice above. The result is one wide synchronous counter in which every bit changes on the same edge.

A build parameter selects how clear behaves. In one variant, clear zeroes the count the moment it goes low, whatever the clock is doing. In the other variant, clear acts only at a rising clock edge. Priority is fixed: clear, then load, then counting. A load does not look at either enable.

Top module: `cascade_counter`

## Requirements
- R1: The count `q` changes only at a rising edge of `clk`. The one exception is the immediate clear of R4. When `load_n` is high and either enable is low, `q` keeps its value across the edge.
- R2: A rising edge with `load_n` low copies `data` into `q`, whatever the values of `cnt_en` and `carry_en`.
- R3: Only the level of `load_n` at the rising edge matters. A low pulse on `load_n` that ends before the edge leaves that edge free to count as usual.
- R4: With `ASYNC_CLR`=1, a low `clear_n` forces `q` to zero at once, without waiting for a clock edge.
- R5: With `ASYNC_CLR`=0, `q` becomes zero at a rising edge where `clear_n` is low. Before that edge `q` is unchanged. Clear takes priority over load.
- R6: With `clear_n` and `load_n` both high and both enables high, `q` increases by one at each rising edge.
- R7: `rc` is high exactly when `carry_en` is high and `q` is all ones. `rc` follows `carry_en` with no clock delay.
- R8: In the chain, a slice advances only when every slice below it holds 15 and `carry_en` is high. The whole word wraps from all ones to zero in a single edge.
- R9: After a clear, `q` is zero and `rc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| clear_n | input | 1 | Active-low clear (mode set by ASYNC_CLR) |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable that does not touch the carry |
| carry_en | input | 1 | Count enable that also gates `rc` |
| data | input | 4*STAGES | Preset value |
| q | output | 4*STAGES | Current count |
| rc | output | 1 | Terminal-count carry of the top slice |

## Verification
Load, count, hold and the synchronous clear are all due one rising edge after the inputs are driven. The driver sets the inputs just after a falling edge and queues the value that is due after the next rising edge. The monitor then compares that value a quarter period after that rising edge. Two results need no edge: `rc` and the asynchronous clear. For these, the bench changes an input in the middle of the low clock phase and checks the output a few time units later, before any edge can occur. The same probe confirms that the synchronous build still holds its old count until the edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int STAGE_W = 4;

    typedef logic [STAGE_W-1:0] nib_t;

    typedef struct packed {
        nib_t cnt;
    } stage_st_t;

    localparam nib_t      CNT_TERM  = '1;
    localparam stage_st_t STAGE_RST = '{cnt: '0};
endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic clk,
    input  logic clear_n,
    input  logic load_n,
    input  logic cnt_en,
    input  logic carry_en,
    input  nib_t din,
    output nib_t q,
    output logic rc
);
    stage_st_t st_d, st_q;

    // next-state: clear (sync build only) > load > count > hold
    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.cnt = din;
        end else if (cnt_en && carry_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!ASYNC_CLR && !clear_n) begin
            st_d = STAGE_RST;
        end
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) st_q <= STAGE_RST;
                else          st_q <= st_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign q  = st_q.cnt;
    assign rc = carry_en && (st_q.cnt == CNT_TERM);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int STAGES    = 2,
    parameter bit ASYNC_CLR = 1'b0,
    localparam int W        = STAGES * STAGE_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic         carry_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rc
);
    logic [STAGES-1:0] rc_s;
    logic [STAGES-1:0] ten_s;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_low
                assign ten_s[i] = carry_en;
            end else begin : g_up
                assign ten_s[i] = rc_s[i-1];
            end

            cnt_stage #(.ASYNC_CLR(ASYNC_CLR)) u_stage (
                .clk      (clk),
                .clear_n  (clear_n),
                .load_n   (load_n),
                .cnt_en   (cnt_en),
                .carry_en (ten_s[i]),
                .din      (din[i*STAGE_W +: STAGE_W]),
                .q        (q[i*STAGE_W +: STAGE_W]),
                .rc       (rc_s[i])
            );
        end
    endgenerate

    assign rc = rc_s[STAGES-1];
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
    parameter int STAGES    = 2,
    parameter bit ASYNC_CLR = 1'b0,
    localparam int W        = STAGES * cnt_pkg::STAGE_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic         carry_en,
    input  logic [W-1:0] data,
    output logic [W-1:0] q,
    output logic         rc
);
    cnt_chain #(.STAGES(STAGES), .ASYNC_CLR(ASYNC_CLR)) u_chain (
        .clk      (clk),
        .clear_n  (clear_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_en (carry_en),
        .din      (data),
        .q        (q),
        .rc       (rc)
    );
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int W         = 8,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic         clk,
    input logic         clear_n,
    input logic         load_n,
    input logic         cnt_en,
    input logic         carry_en,
    input logic [W-1:0] data,
    input logic [W-1:0] q,
    input logic         rc
);
    logic clr_at_edge_q;

    always_ff @(posedge clk) clr_at_edge_q <= !clear_n;

    assert_load_copies_R2: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> q == $past(data));

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(q));

    assert_step_one_R6: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_en && carry_en) |=> q == W'($past(q) + 1'b1));

    assert_carry_set_R7: assert property (@(posedge clk) disable iff (!clear_n)
        rc |-> (carry_en && (&q)));

    assert_carry_due_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (carry_en && (&q)) |-> rc);

    always @(negedge clk) begin
        if (ASYNC_CLR && !clear_n) begin
            assert_async_zero_R4: assert (q == '0);
        end
        if (!ASYNC_CLR && clr_at_edge_q) begin
            assert_sync_zero_R5: assert (q == '0);
        end
    end
endmodule

bind cascade_counter cascade_counter_chk #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .data     (data),
    .q        (q),
    .rc       (rc)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
    localparam int CLK_P  = 10;
    localparam int STAGES = 2;
    localparam int W      = STAGES * 4;

    typedef struct {
        logic [W-1:0] q;
        logic         rc;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         clear_n, load_n, cnt_en, carry_en;
    logic [W-1:0] data;
    logic [W-1:0] q_s, q_a;
    logic         rc_s, rc_a;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t sb[$];
    logic [W-1:0] model;

    always #(CLK_P/2) clk = ~clk;

    cascade_counter #(.STAGES(STAGES), .ASYNC_CLR(1'b0)) dut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .data(data), .q(q_s), .rc(rc_s));

    cascade_counter #(.STAGES(STAGES), .ASYNC_CLR(1'b1)) dut_async (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .data(data), .q(q_a), .rc(rc_a));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: apply inputs after a falling edge, queue the result due after the next rising edge
    task automatic drive(input bit clr, input bit ld, input bit p, input bit t,
                         input logic [W-1:0] d, input string tag, input bit glitch = 1'b0);
        exp_t e;
        @(negedge clk);
        #1;
        clear_n = clr; load_n = ld; cnt_en = p; carry_en = t; data = d;
        if (glitch) begin
            load_n = 1'b0;
            #2;
            load_n = 1'b1;
        end
        if (!clr)               model = '0;
        else if (!ld)           model = d;
        else if (p && t)        model = model + 1'b1;
        e.q   = model;
        e.rc  = t && (model == '1);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(q_s == e.q,  e.tag, "sync q",   q_s, e.q);
            check(rc_s == e.rc, e.tag, "sync rc",  {7'b0, rc_s}, {7'b0, e.rc});
            check(q_a == e.q,  e.tag, "async q",  q_a, e.q);
            check(rc_a == e.rc, e.tag, "async rc", {7'b0, rc_a}, {7'b0, e.rc});
        end
    end

    initial begin
        clear_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0; data = '0;
        model = '0;
        #1;
        check(q_a == '0, "R4", "async q before any edge", q_a, '0);

        drive(0, 0, 1, 1, 8'h55, "R5");              // clear wins over load
        drive(0, 1, 0, 1, 8'h00, "R9");
        drive(1, 0, 0, 0, 8'h0C, "R2");              // load with enables low
        drive(1, 1, 1, 1, 8'h00, "R6");              // 0D
        drive(1, 1, 1, 1, 8'h00, "R6");              // 0E
        drive(1, 1, 1, 1, 8'h00, "R6");              // 0F
        drive(1, 1, 1, 1, 8'h00, "R8");              // 10: carry into upper slice
        drive(1, 1, 1, 1, 8'h00, "R6");              // 11
        drive(1, 1, 0, 1, 8'h00, "R1");              // hold, cnt_en low
        drive(1, 1, 1, 0, 8'h00, "R1");              // hold, carry_en low
        drive(1, 1, 1, 1, 8'hAA, "R3", 1'b1);        // released load: counts to 12
        drive(1, 0, 1, 1, 8'hFE, "R2");              // load beats enables
        drive(1, 1, 1, 1, 8'h00, "R7");              // FF, rc high

        // rc follows carry_en without a clock
        @(negedge clk);
        #1;
        cnt_en = 1'b0; carry_en = 1'b0;
        #1;
        check(rc_s == 1'b0, "R7", "sync rc after carry_en fell",  {7'b0, rc_s}, 8'h00);
        check(rc_a == 1'b0, "R7", "async rc after carry_en fell", {7'b0, rc_a}, 8'h00);
        carry_en = 1'b1;
        #1;
        check(rc_s == 1'b1, "R7", "sync rc after carry_en rose",  {7'b0, rc_s}, 8'h01);
        check(rc_a == 1'b1, "R7", "async rc after carry_en rose", {7'b0, rc_a}, 8'h01);
        begin
            exp_t e;
            e.q = model; e.rc = 1'b1; e.tag = "R1";
            sb.push_back(e);
        end

        drive(1, 1, 1, 1, 8'h00, "R8");              // FF -> 00 wrap
        drive(1, 0, 1, 1, 8'h3F, "R2");
        drive(1, 1, 1, 0, 8'h00, "R7");              // 3F held, rc low (low slice at 15 but carry_en low)
        drive(1, 1, 1, 1, 8'h00, "R8");              // 40

        // clear in the middle of the low phase
        @(negedge clk);
        #1;
        clear_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0;
        #2;
        check(q_a == '0,    "R4", "async q right after clear", q_a, '0);
        check(q_s == 8'h40, "R5", "sync q before edge",        q_s, 8'h40);
        model = '0;
        begin
            exp_t e;
            e.q = '0; e.rc = 1'b0; e.tag = "R5";
            sb.push_back(e);
        end

        drive(1, 1, 1, 1, 8'h00, "R6");              // 01
        drive(1, 1, 1, 1, 8'h00, "R6");              // 02

        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule